// File: doc/BRIEF.md
# Status Channel Frame Generator

This block runs in the system clock domain and produces the 2-bit word stream of a receive-side flow-control status channel. Each frame opens with a framing word and a calendar-select word. These are followed by the per-slot FIFO status words for the calendar, repeated a set number of times, and the frame closes with a DIP-2 parity word. The next frame then starts at once. The generator maps each calendar slot to a port, either one to one or through a small programmable calendar table. It asks an external status source for that port's code and passes the code downstream.

Words go into a downstream clock-crossing FIFO, and the generator produces a word only in a cycle where that FIFO reports free space. The output can be forced to a continuous all-ones pattern. This happens when software asks for it, when a control pin asks for it, or when the FIFO reports an overflow or underflow. A flag reports the forced state. The forced state from a FIFO error is held until software sets its disable bit. Software is expected to load the calendar table while the generator is disabled.

Top module: `stat_frame_gen`

## Requirements
- R1: `word_wr` is high in the cycle after a cycle where `fifo_space` was high, and low in the cycle after a cycle where it was low. The frame position advances only on cycles with space.
- R2: On enabled cycles with space, the frame is written in this order: 2'b11, then the select word {1'b0, `cal_sel`}, then CAL_LEN×CAL_M slot words, then the DIP word. After the DIP word the frame starts again.
- R3: In the cycle that a slot word is taken, `stat_req` is high and `stat_code` is sampled. The word written one cycle later equals that code, except that 2'b11 becomes 2'b10. `stat_req` is low at all other times.
- R4: With ASYM=0, slot k (counted from 0 within the calendar) is mapped to port k.
- R5: With ASYM=1, slot k is mapped to the port held in calendar entry k. An entry is written by `cal_we` with `cal_addr`=k and `cal_port`.
- R6: A calendar write in a cycle where the generator is enabled is ignored.
- R7: The DIP word equals the bitwise XOR of the select word and every slot word of the same frame.
- R8: While `ctl_disable` or `sw_disable` is high, every written word is 2'b11. `disabled` goes high one cycle after either input is seen, and no status is requested.
- R9: A one-cycle pulse on `fifo_err` disables the generator in the same way as R8. It stays disabled until `sw_disable` is seen high while `fifo_err` is low.
- R10: The first word written after the generator leaves the disabled state is the framing word 2'b11, and a complete frame follows it.
- R11: During reset, `word_wr`, `disabled` and `stat_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_space | input | 1 | Downstream FIFO can take a word this cycle |
| fifo_err | input | 1 | Downstream FIFO overflow or underflow pulse |
| ctl_disable | input | 1 | Pin request to force the disabled pattern |
| sw_disable | input | 1 | Software request to force the disabled pattern; also clears a held error |
| cal_sel | input | 1 | Calendar-select value carried in the select word |
| cal_we | input | 1 | Calendar table write strobe |
| cal_addr | input | SLOT_W | Calendar entry (slot) to write |
| cal_port | input | PORT_W | Port number to store in the entry |
| stat_req | output | 1 | Status for `stat_port` is being taken this cycle |
| stat_port | output | PORT_W | Port mapped to the current slot |
| stat_code | input | 2 | Status code returned for `stat_port` in the same cycle |
| word_out | output | 2 | Status word for the downstream FIFO |
| word_wr | output | 1 | Write strobe for `word_out` |
| disabled | output | 1 | Output is forced to the continuous 2'b11 pattern |

## Verification
The slot-to-port lookup and `stat_req` depend only on present state and inputs. They are checked in the same cycle the stimulus is applied, shortly after the falling edge. The written word, `word_wr` and `disabled` each pass through one register. They are compared at the next falling edge, against a bench model that is advanced once per cycle in step with the design. A FIFO error pulse or a change of a disable input therefore shows up exactly one cycle later, and the sticky error is tracked in the model across later cycles. Sweeps cover every status-code rotation, three space patterns and both map variants.

// File: rtl/stat_frame_pkg.sv
package stat_frame_pkg;
  typedef enum logic [1:0] {
    PH_FRAME = 2'd0,
    PH_SEL   = 2'd1,
    PH_SLOT  = 2'd2,
    PH_DIP   = 2'd3
  } phase_t;

  localparam logic [1:0] WORD_ONES = 2'b11;

  // status codes are restricted to 00/01/10; 11 is reserved for framing
  function automatic logic [1:0] clamp_code(input logic [1:0] c);
    return (c == 2'b11) ? 2'b10 : c;
  endfunction
endpackage

// File: rtl/stat_seq.sv
module stat_seq
  import stat_frame_pkg::*;
#(
  parameter int CAL_LEN = 3,
  parameter int CAL_M   = 2,
  parameter int SLOT_W  = 2,
  parameter int REP_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              adv,
  output phase_t            phase,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(CAL_LEN - 1);
  localparam logic [REP_W-1:0]  REP_LAST  = REP_W'(CAL_M - 1);

  phase_t            phase_q;
  logic [SLOT_W-1:0] slot_q;
  logic [REP_W-1:0]  rep_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= PH_FRAME;
      slot_q  <= '0;
      rep_q   <= '0;
    end else if (adv) begin
      case (phase_q)
        PH_FRAME: phase_q <= PH_SEL;
        PH_SEL:   phase_q <= PH_SLOT;
        PH_SLOT: begin
          if (slot_q == SLOT_LAST) begin
            slot_q <= '0;
            if (rep_q == REP_LAST) begin
              rep_q   <= '0;
              phase_q <= PH_DIP;
            end else begin
              rep_q <= rep_q + 1'b1;
            end
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        default:  phase_q <= PH_FRAME;
      endcase
    end
  end

  assign phase = phase_q;
  assign slot  = slot_q;
endmodule

// File: rtl/stat_cal_map.sv
module stat_cal_map #(
  parameter int ASYM    = 1,
  parameter int CAL_LEN = 3,
  parameter int SLOT_W  = 2,
  parameter int PORT_W  = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [PORT_W-1:0] wport,
  input  logic [SLOT_W-1:0] slot,
  output logic [PORT_W-1:0] port
);
  generate
    if (ASYM != 0) begin : g_table
      logic [PORT_W-1:0] cal_mem [CAL_LEN];

      always_ff @(posedge clk) begin
        if (we && (int'(waddr) < CAL_LEN)) cal_mem[waddr] <= wport;
      end

      assign port = cal_mem[slot];
    end else begin : g_identity
      logic unused_wr;
      assign unused_wr = ^{clk, we, waddr, wport};
      assign port      = PORT_W'(slot);
    end
  endgenerate
endmodule

// File: rtl/stat_frame_gen.sv
module stat_frame_gen
  import stat_frame_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CAL_LEN   = 3,
  parameter int CAL_M     = 2,
  parameter int ASYM      = 1,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int SLOT_W   = (CAL_LEN > 1) ? $clog2(CAL_LEN) : 1,
  localparam int REP_W    = (CAL_M > 1) ? $clog2(CAL_M) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_space,
  input  logic              fifo_err,
  input  logic              ctl_disable,
  input  logic              sw_disable,
  input  logic              cal_sel,
  input  logic              cal_we,
  input  logic [SLOT_W-1:0] cal_addr,
  input  logic [PORT_W-1:0] cal_port,
  output logic              stat_req,
  output logic [PORT_W-1:0] stat_port,
  input  logic [1:0]        stat_code,
  output logic [1:0]        word_out,
  output logic              word_wr,
  output logic              disabled
);
  logic              err_q;
  logic              dis_c;
  logic              adv;
  phase_t            phase;
  logic [SLOT_W-1:0] slot;
  logic [1:0]        acc_q;
  logic [1:0]        word_c;
  logic [1:0]        word_q;
  logic              wr_q;
  logic              dis_q;

  assign dis_c = ctl_disable | sw_disable | err_q | fifo_err;
  assign adv   = fifo_space & ~dis_c;

  stat_seq #(
    .CAL_LEN (CAL_LEN),
    .CAL_M   (CAL_M),
    .SLOT_W  (SLOT_W),
    .REP_W   (REP_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .restart (dis_c),
    .adv     (adv),
    .phase   (phase),
    .slot    (slot)
  );

  stat_cal_map #(
    .ASYM    (ASYM),
    .CAL_LEN (CAL_LEN),
    .SLOT_W  (SLOT_W),
    .PORT_W  (PORT_W)
  ) u_map (
    .clk   (clk),
    .we    (cal_we & dis_c),
    .waddr (cal_addr),
    .wport (cal_port),
    .slot  (slot),
    .port  (stat_port)
  );

  always_comb begin
    case (phase)
      PH_FRAME: word_c = WORD_ONES;
      PH_SEL:   word_c = {1'b0, cal_sel};
      PH_SLOT:  word_c = clamp_code(stat_code);
      default:  word_c = ~acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= 1'b0;
      acc_q  <= 2'b00;
      word_q <= WORD_ONES;
      wr_q   <= 1'b0;
      dis_q  <= 1'b0;
    end else begin
      err_q <= fifo_err | (err_q & ~sw_disable);
      if (adv) begin
        if (phase == PH_FRAME)                      acc_q <= WORD_ONES;
        else if (phase == PH_SEL || phase == PH_SLOT) acc_q <= acc_q ^ word_c;
      end
      word_q <= dis_c ? WORD_ONES : word_c;
      wr_q   <= fifo_space;
      dis_q  <= dis_c;
    end
  end

  assign stat_req = adv & (phase == PH_SLOT);
  assign word_out = word_q;
  assign word_wr  = wr_q;
  assign disabled = dis_q;
endmodule

// File: rtl/stat_frame_chk.sv
module stat_frame_chk (
  input logic       clk,
  input logic       rst,
  input logic       fifo_space,
  input logic       fifo_err,
  input logic       ctl_disable,
  input logic       sw_disable,
  input logic       stat_req,
  input logic [1:0] word_out,
  input logic       word_wr,
  input logic       disabled
);
  p_wr_space_r1: assert property (@(posedge clk) disable iff (rst)
    fifo_space |=> word_wr);
  p_wr_nospace_r1: assert property (@(posedge clk) disable iff (rst)
    !fifo_space |=> !word_wr);
  p_req_gate_r3: assert property (@(posedge clk) disable iff (rst)
    stat_req |-> (fifo_space && !ctl_disable && !sw_disable && !fifo_err));
  p_req_clamp_r3: assert property (@(posedge clk) disable iff (rst)
    stat_req |=> (word_wr && word_out != 2'b11 && !disabled));
  p_dis_ones_r8: assert property (@(posedge clk) disable iff (rst)
    (disabled && word_wr) |-> (word_out == 2'b11));
  p_dis_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl_disable || sw_disable) |=> disabled);
  p_err_flag_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_err |=> disabled);
endmodule

bind stat_frame_gen stat_frame_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .fifo_space  (fifo_space),
  .fifo_err    (fifo_err),
  .ctl_disable (ctl_disable),
  .sw_disable  (sw_disable),
  .stat_req    (stat_req),
  .word_out    (word_out),
  .word_wr     (word_wr),
  .disabled    (disabled)
);

// File: tb/tb_stat_frame_gen.sv
`timescale 1ns/1ps
module tb_stat_frame_gen;
  localparam int NUM_PORTS = 4;
  localparam int CAL_LEN   = 3;
  localparam int CAL_M     = 2;
  localparam int NSLOT     = CAL_LEN * CAL_M;
  localparam int LASTPOS   = NSLOT + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_space = 1'b0, fifo_err = 1'b0, ctl_disable = 1'b0, sw_disable = 1'b1;
  logic cal_sel = 1'b0, cal_we = 1'b0;
  logic [1:0] cal_addr = '0, cal_port = '0;
  logic stat_req, stat_req_id;
  logic [1:0] stat_port, stat_port_id, stat_code, stat_code_id;
  logic [1:0] word_out, word_out_id;
  logic word_wr, word_wr_id, disabled, disabled_id;

  int cbase = 0;
  int n_chk = 0, n_fail = 0;
  int pos = 0;
  int acc = 0;
  bit err_m = 1'b0;
  int calm [CAL_LEN];

  always #10 clk = ~clk;

  assign stat_code    = 2'((int'(stat_port) + cbase) % 4);
  assign stat_code_id = 2'((int'(stat_port_id) + cbase) % 4);

  stat_frame_gen #(.NUM_PORTS(NUM_PORTS), .CAL_LEN(CAL_LEN), .CAL_M(CAL_M), .ASYM(1)) dut (
    .clk(clk), .rst(rst), .fifo_space(fifo_space), .fifo_err(fifo_err),
    .ctl_disable(ctl_disable), .sw_disable(sw_disable), .cal_sel(cal_sel),
    .cal_we(cal_we), .cal_addr(cal_addr), .cal_port(cal_port),
    .stat_req(stat_req), .stat_port(stat_port), .stat_code(stat_code),
    .word_out(word_out), .word_wr(word_wr), .disabled(disabled));

  stat_frame_gen #(.NUM_PORTS(NUM_PORTS), .CAL_LEN(CAL_LEN), .CAL_M(CAL_M), .ASYM(0)) dut_id (
    .clk(clk), .rst(rst), .fifo_space(fifo_space), .fifo_err(fifo_err),
    .ctl_disable(ctl_disable), .sw_disable(sw_disable), .cal_sel(cal_sel),
    .cal_we(cal_we), .cal_addr(cal_addr), .cal_port(cal_port),
    .stat_req(stat_req_id), .stat_port(stat_port_id), .stat_code(stat_code_id),
    .word_out(word_out_id), .word_wr(word_wr_id), .disabled(disabled_id));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: called right after a falling edge with control inputs set
  task automatic tick(input bit space);
    bit dis, exp_req;
    int ew, slot, p;
    string tg;
    fifo_space = space;
    #1;
    dis = ctl_disable | sw_disable | err_m | fifo_err;
    exp_req = !dis && space && pos >= 2 && pos < 2 + NSLOT;
    chk(stat_req == exp_req, "R3 stat_req", int'(stat_req), int'(exp_req));
    ew = 3; tg = "R8 forced ones";
    if (!dis) begin
      if (pos == 0) begin ew = 3; tg = "R2 framing / R10 restart"; end
      else if (pos == 1) begin ew = int'(cal_sel); tg = "R2 select word"; end
      else if (pos < 2 + NSLOT) begin
        slot = (pos - 2) % CAL_LEN;
        p = calm[slot];
        if (exp_req) begin
          chk(int'(stat_port) == p, "R5 calendar port", int'(stat_port), p);
          chk(int'(stat_port_id) == slot, "R4 identity port", int'(stat_port_id), slot);
        end
        ew = (p + cbase) % 4;
        if (ew == 3) ew = 2;
        tg = "R3 slot status";
      end else begin ew = acc; tg = "R7 DIP word"; end
    end
    if (cal_we && dis) calm[cal_addr] = int'(cal_port);
    if (dis) pos = 0;
    else if (space) begin
      if (pos == 0) acc = 0;
      else if (pos < 2 + NSLOT) acc = acc ^ ew;
      pos = (pos == LASTPOS) ? 0 : pos + 1;
    end
    err_m = fifo_err | (err_m & !sw_disable);
    @(negedge clk);
    chk(word_wr == space, "R1 write strobe", int'(word_wr), int'(space));
    if (space) chk(int'(word_out) == ew, tg, int'(word_out), ew);
    chk(disabled == dis, dis ? "R8 R9 disabled flag" : "R8 flag clear", int'(disabled), int'(dis));
    cal_we = 1'b0;
    fifo_err = 1'b0;
  endtask

  function automatic bit space_pat(input int pat, input int i);
    case (pat)
      0: return 1'b1;
      1: return (i % 2) == 0;
      default: return (i % 3) != 0;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < CAL_LEN; k++) calm[k] = 0;
    fifo_space = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(word_wr == 1'b0, "R11 word_wr in reset", int'(word_wr), 0);
    chk(disabled == 1'b0, "R11 disabled in reset", int'(disabled), 0);
    chk(stat_req == 1'b0, "R11 stat_req in reset", int'(stat_req), 0);
    rst = 1'b0;
    // R5: program calendar while disabled by software
    for (int k = 0; k < CAL_LEN; k++) begin
      cal_we = 1'b1; cal_addr = 2'(k); cal_port = 2'((k * 3 + 2) % NUM_PORTS);
      tick(1'b1);
    end
    sw_disable = 1'b0;
    // sweeps: status rotations x space patterns
    for (int cb = 0; cb < 4; cb++) begin
      cbase = cb;
      cal_sel = cb[0];
      for (int pat = 0; pat < 3; pat++)
        for (int i = 0; i < 3 * (LASTPOS + 1); i++) tick(space_pat(pat, i));
    end
    // R6: writes while enabled are ignored
    for (int i = 0; i < 2 * (LASTPOS + 1); i++) begin
      if (i % 4 == 1) begin
        cal_we = 1'b1; cal_addr = 2'(i % CAL_LEN); cal_port = 2'((i + 1) % NUM_PORTS);
      end
      tick(1'b1);
    end
    // R8 / R10: control pin disable mid-frame, then restart
    for (int i = 0; i < 4; i++) tick(1'b1);
    ctl_disable = 1'b1;
    for (int i = 0; i < 6; i++) tick(space_pat(2, i));
    ctl_disable = 1'b0;
    for (int i = 0; i < 2 * (LASTPOS + 1); i++) tick(space_pat(1, i));
    // R9: error pulse is held until software clears it
    for (int i = 0; i < 5; i++) tick(1'b1);
    fifo_err = 1'b1;
    for (int i = 0; i < 8; i++) tick(1'b1);
    sw_disable = 1'b1;
    cal_we = 1'b1; cal_addr = 2'd1; cal_port = 2'd3;
    tick(1'b1);
    tick(1'b0);
    sw_disable = 1'b0;
    for (int i = 0; i < 3 * (LASTPOS + 1); i++) tick(space_pat(0, i));
    // out-of-range calendar address while disabled has no effect on slots
    sw_disable = 1'b1;
    cal_we = 1'b1; cal_addr = 2'd3; cal_port = 2'd1;
    tick(1'b1);
    sw_disable = 1'b0;
    for (int i = 0; i < 2 * (LASTPOS + 1); i++) tick(1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule